// File: doc/BRIEF.md
# Programmable Clock Rate Divider

This block divides a single input clock by an integer taken from a 32-bit control register. Software writes the register; a field of build-time width and bit offset inside it is turned into the divisor by one of four build-time encodings: field plus one, field taken as is, two to the power of the field, or a lookup into a divisor table in which a zero entry marks a forbidden code. In the three arithmetic encodings the result must also lie between a minimum and a maximum divisor.

A write whose field decodes to a forbidden or out-of-range divisor changes nothing in the divider and raises a sticky error flag, which a read strobe clears. When the commit option is built in, a written field takes effect only if the same write also sets the commit bit. Otherwise every write is a commit. An accepted divisor waits until the running output period ends, so the output never shows a shortened pulse. The output is never gated. The register also holds an autoidle enable bit at a build-time position with selectable polarity, which the block reports on a pin.

Top module: `clkdiv_prog`

## Requirements
- R1: In the field-plus-one encoding a field value f selects divisor f+1, so field 2 gives divide-by-3.
- R2: In the direct encoding a field value f selects divisor f, and field 0 is rejected.
- R3: In the power-of-two encoding a field value f selects divisor 2^f, so fields 0, 1, 2, 3 give 1, 2, 4, 8.
- R4: In the table encoding the field indexes the divisor table (entry i at bits [16*i +: 16] of the table parameter). A zero entry or an index past the end of the table is rejected, and the minimum and maximum limits are not applied.
- R5: In the three arithmetic encodings a decoded divisor below the minimum or above the maximum is rejected.
- R6: A rejected commit leaves the effective divisor unchanged and sets the error output in the next cycle. The error output stays set until a read strobe clears it, and the read data always shows the last written register value.
- R7: With the commit option built in, a write whose commit bit is 0 stores the register but leaves the divisor unchanged. A write with the commit bit at 1 commits the field of that same write.
- R8: A new divisor takes effect only at the end of a complete output period. The output period is the divisor in input cycles, and the high phase is floor(divisor/2) cycles, so odd divisors are high one cycle less than low. Divisor 1 passes the input clock through.
- R9: The autoidle output equals the register bit at the autoidle position, inverted when the inversion option is set.
- R10: Only the bits of the divider field, at its build-time offset, affect the divisor. Other register bits do not.
- R11: After reset the register reads 0, the error output is 0 and the effective divisor is the reset divisor parameter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Read strobe; clears the error flag |
| rd_data | output | 32 | Current register value |
| clk_out | output | 1 | Divided clock |
| div_eff | output | 16 | Divisor in effect now |
| autoidle | output | 1 | Autoidle enable with polarity applied |
| err | output | 1 | Sticky flag for a rejected divisor |

## Verification
The assertions check on every cycle that the phase counter stays below the divisor in effect, that the divisor changes only at the last cycle of a period, that a rejected commit raises the error flag and a read clears it, that a write without the commit bit never creates an update, that the autoidle output only moves after a write, and that the divisor in effect stays within the limits. The exact decoding of each encoding, the table holes, the output period and high-phase length for even, odd and unit divisors, and the field offset can only be shown by the bench. It programs four builds, one per encoding, and measures the divided clock directly.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int CD_DIV_W = 16;

    typedef logic [CD_DIV_W-1:0] div_t;

    typedef enum logic [1:0] {
        ENC_MINUS1 = 2'd0,
        ENC_DIRECT = 2'd1,
        ENC_POW2   = 2'd2,
        ENC_TABLE  = 2'd3
    } enc_e;

    // decoded or pending divisor with its qualifier
    typedef struct packed {
        logic valid;
        div_t div;
    } upd_t;

    // length of the high phase for a divisor
    function automatic div_t hi_len(input div_t d);
        return d >> 1;
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter enc_e        MODE      = ENC_MINUS1,
    parameter int          FIELD_LSB = 0,
    parameter int          FIELD_W   = 4,
    parameter int          MIN_DIV   = 1,
    parameter int          MAX_DIV   = 16,
    parameter int          TBL_N     = 4,
    parameter logic [TBL_N*CD_DIV_W-1:0] TBL = '0
) (
    input  logic [31:0] wr_data,
    output upd_t        dec
);
    localparam int WIDE_W = 34;

    logic [FIELD_W-1:0] fld;
    assign fld = wr_data[FIELD_LSB +: FIELD_W];

    generate
        if (MODE == ENC_TABLE) begin : g_table
            always_comb begin
                dec = '0;
                for (int i = 0; i < TBL_N; i++) begin
                    if (int'(fld) == i) begin
                        dec.div   = TBL[i*CD_DIV_W +: CD_DIV_W];
                        dec.valid = (TBL[i*CD_DIV_W +: CD_DIV_W] != '0);
                    end
                end
            end
        end else begin : g_arith
            logic [WIDE_W-1:0] wide;
            always_comb begin
                case (MODE)
                    ENC_MINUS1: wide = WIDE_W'(fld) + WIDE_W'(1);
                    ENC_DIRECT: wide = WIDE_W'(fld);
                    default:    wide = (int'(fld) < 33) ? (WIDE_W'(1) << fld) : '0;
                endcase
                dec.div   = wide[CD_DIV_W-1:0];
                dec.valid = (wide != '0)
                         && (wide >= WIDE_W'(MIN_DIV))
                         && (wide <= WIDE_W'(MAX_DIV))
                         && (wide < (WIDE_W'(1) << CD_DIV_W));
            end
        end
    endgenerate
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
    import clkdiv_pkg::*;
#(
    parameter bit LATCH_EN  = 1'b0,
    parameter int LATCH_BIT = 31
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    input  upd_t        dec,
    output logic [31:0] reg_q,
    output logic        err,
    output upd_t        upd
);
    logic commit;

    generate
        if (LATCH_EN) begin : g_latch
            assign commit = wr_en && wr_data[LATCH_BIT];
        end else begin : g_nolatch
            assign commit = wr_en;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
            err   <= 1'b0;
            upd   <= '0;
        end else begin
            upd.valid <= 1'b0;
            if (wr_en)
                reg_q <= wr_data;
            if (commit && dec.valid)
                upd <= '{valid: 1'b1, div: dec.div};
            err <= (err && !rd_en) || (commit && !dec.valid);
        end
    end

    // R6
    bad_sets_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !dec.valid && (!LATCH_EN || wr_data[LATCH_BIT])) |=> err);

    // R6
    read_clears_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !(wr_en && !dec.valid)) |=> !err);

    // R7
    no_commit_no_upd_chk: assert property (@(posedge clk) disable iff (rst)
        (LATCH_EN && wr_en && !wr_data[LATCH_BIT]) |=> !upd.valid);
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
    import clkdiv_pkg::*;
#(
    parameter int RST_DIV = 1
) (
    input  logic clk,
    input  logic rst,
    input  upd_t upd,
    output logic clk_out,
    output div_t div_cur
);
    div_t cnt;
    div_t cnt_n;
    div_t div_n;
    upd_t pend;
    logic ph_q;
    logic bypass_q;
    logic at_end;

    assign at_end = (cnt == div_cur - div_t'(1));

    always_comb begin
        div_n = div_cur;
        cnt_n = cnt + div_t'(1);
        if (at_end) begin
            cnt_n = '0;
            if (pend.valid)
                div_n = pend.div;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            div_cur  <= div_t'(RST_DIV);
            pend     <= '0;
            ph_q     <= 1'b0;
            bypass_q <= (RST_DIV == 1);
        end else begin
            cnt      <= cnt_n;
            div_cur  <= div_n;
            ph_q     <= (cnt_n < hi_len(div_n));
            bypass_q <= (div_n == div_t'(1));
            if (upd.valid)
                pend <= upd;
            else if (at_end)
                pend.valid <= 1'b0;
        end
    end

    assign clk_out = bypass_q ? clk : ph_q;

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < div_cur);

    // R8
    switch_at_end_chk: assert property (@(posedge clk) disable iff (rst)
        !at_end |=> $stable(div_cur));
endmodule

// File: rtl/clkdiv_prog.sv
module clkdiv_prog
    import clkdiv_pkg::*;
#(
    parameter enc_e MODE      = ENC_MINUS1,
    parameter int   FIELD_LSB = 0,
    parameter int   FIELD_W   = 4,
    parameter int   MIN_DIV   = 1,
    parameter int   MAX_DIV   = 16,
    parameter int   TBL_N     = 4,
    parameter logic [TBL_N*CD_DIV_W-1:0] TBL = '0,
    parameter int   AIDLE_BIT = 16,
    parameter bit   AIDLE_INV = 1'b0,
    parameter bit   LATCH_EN  = 1'b0,
    parameter int   LATCH_BIT = 31,
    parameter int   RST_DIV   = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    output logic        clk_out,
    output logic [15:0] div_eff,
    output logic        autoidle,
    output logic        err
);
    upd_t        dec;
    upd_t        upd;
    logic [31:0] reg_q;
    div_t        div_cur;

    clkdiv_decode #(
        .MODE(MODE), .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W),
        .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .TBL_N(TBL_N), .TBL(TBL)
    ) u_dec (
        .wr_data(wr_data),
        .dec    (dec)
    );

    clkdiv_ctrl #(
        .LATCH_EN(LATCH_EN), .LATCH_BIT(LATCH_BIT)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .dec    (dec),
        .reg_q  (reg_q),
        .err    (err),
        .upd    (upd)
    );

    clkdiv_gen #(
        .RST_DIV(RST_DIV)
    ) u_gen (
        .clk    (clk),
        .rst    (rst),
        .upd    (upd),
        .clk_out(clk_out),
        .div_cur(div_cur)
    );

    assign rd_data  = reg_q;
    assign div_eff  = div_cur;
    assign autoidle = reg_q[AIDLE_BIT] ^ AIDLE_INV;

    // R5
    limit_chk: assert property (@(posedge clk) disable iff (rst)
        (MODE != ENC_TABLE) |-> (int'(div_eff) >= MIN_DIV && int'(div_eff) <= MAX_DIV));

    // R4
    nonzero_div_chk: assert property (@(posedge clk) disable iff (rst)
        div_eff != '0);

    // R9
    autoidle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(autoidle));
endmodule

// File: tb/clkdiv_prog_test.sv
module clkdiv_prog_test;
    import clkdiv_pkg::*;

    typedef struct {
        string req;
        int    act;
        int    exp;
    } item_t;

    item_t sbq[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;

    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  wen = '0;
    logic [31:0] wdat = '0;
    logic        ren = 0;
    logic [31:0] rdd [4];
    logic [15:0] de  [4];
    logic [3:0]  co;
    logic [3:0]  ai;
    logic [3:0]  er;

    always #5 clk = ~clk; // 100 MHz

    // 0: field-plus-one, field at bit 4, commit bit 31, autoidle bit 0 inverted
    clkdiv_prog #(.MODE(ENC_MINUS1), .FIELD_LSB(4), .FIELD_W(4), .MIN_DIV(1), .MAX_DIV(12),
                  .AIDLE_BIT(0), .AIDLE_INV(1'b1), .LATCH_EN(1'b1), .LATCH_BIT(31),
                  .RST_DIV(1)) uut (
        .clk(clk), .rst(rst), .wr_en(wen[0]), .wr_data(wdat), .rd_en(ren), .rd_data(rdd[0]),
        .clk_out(co[0]), .div_eff(de[0]), .autoidle(ai[0]), .err(er[0]));

    // 1: direct, limits 2..15
    clkdiv_prog #(.MODE(ENC_DIRECT), .FIELD_LSB(0), .FIELD_W(4), .MIN_DIV(2), .MAX_DIV(15),
                  .RST_DIV(2)) uut_dir (
        .clk(clk), .rst(rst), .wr_en(wen[1]), .wr_data(wdat), .rd_en(ren), .rd_data(rdd[1]),
        .clk_out(co[1]), .div_eff(de[1]), .autoidle(ai[1]), .err(er[1]));

    // 2: power of two, field at bit 8, limits 1..32
    clkdiv_prog #(.MODE(ENC_POW2), .FIELD_LSB(8), .FIELD_W(3), .MIN_DIV(1), .MAX_DIV(32),
                  .RST_DIV(1)) uut_pow (
        .clk(clk), .rst(rst), .wr_en(wen[2]), .wr_data(wdat), .rd_en(ren), .rd_data(rdd[2]),
        .clk_out(co[2]), .div_eff(de[2]), .autoidle(ai[2]), .err(er[2]));

    // 3: table 4,8,0,16,2,0,6,3 (index 0 first)
    clkdiv_prog #(.MODE(ENC_TABLE), .FIELD_LSB(0), .FIELD_W(4), .TBL_N(8),
                  .TBL({16'd3, 16'd6, 16'd0, 16'd2, 16'd16, 16'd0, 16'd8, 16'd4}),
                  .MIN_DIV(1), .MAX_DIV(2), .RST_DIV(4)) uut_tbl (
        .clk(clk), .rst(rst), .wr_en(wen[3]), .wr_data(wdat), .rd_en(ren), .rd_data(rdd[3]),
        .clk_out(co[3]), .div_eff(de[3]), .autoidle(ai[3]), .err(er[3]));

    task automatic push(input string req, input int act, input int exp);
        item_t it;
        it.req = req; it.act = act; it.exp = exp;
        sbq.push_back(it);
    endtask

    // monitor: pops expected items and compares
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            n_tests++;
            if (it.act != it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %0d expected %0d", it.req, it.act, it.exp);
            end
        end
    end

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk);
        wdat = d;
        wen[i] = 1'b1;
        @(negedge clk);
        wen = '0;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        ren = 1'b1;
        @(negedge clk);
        ren = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    // samples clk_out twice per input cycle; returns period and high time in half cycles
    task automatic measure(input int i, output int per_h, output int hi_h);
        logic prev;
        int   cnt;
        @(posedge clk);
        #2;
        prev = co[i];
        cnt = 0;
        while (!(prev == 1'b0 && co[i] == 1'b1) && cnt < 1000) begin
            prev = co[i]; #5; cnt++;
        end
        hi_h = 0; per_h = 0;
        prev = co[i];
        while (co[i] == 1'b1 && per_h < 1000) begin
            hi_h++; per_h++; #5;
        end
        while (co[i] == 1'b0 && per_h < 1000) begin
            per_h++; #5;
        end
    endtask

    task automatic chk_clock(input string req, input int i, input int div);
        int p, h;
        measure(i, p, h);
        push({req, " period"}, p, 2 * div);
        push({req, " high"}, h, (div == 1) ? 1 : 2 * (div / 2));
    endtask

    task automatic finish_run();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        push("R11 rd_data", int'(rdd[0]), 0);
        push("R11 err", int'(er), 0);
        push("R11 div", int'(de[0]), 1);
        push("R11 div dir", int'(de[1]), 2);
        push("R11 div tbl", int'(de[3]), 4);
        // R9 register bit 0 is 0, inverted -> 1
        push("R9 autoidle reset", int'(ai[0]), 1);

        // R7 write without commit bit
        wr(0, 32'h0000_0020);
        settle();
        push("R7 no commit div", int'(de[0]), 1);
        push("R6 read data", int'(rdd[0]), 32'h20);

        // R7 commit with field 2 -> R1 divide by 3
        wr(0, 32'h8000_0020);
        settle();
        push("R1 div", int'(de[0]), 3);
        chk_clock("R8 odd", 0, 3);

        // R5 field 15 -> 16 above max 12
        wr(0, 32'h8000_00F0);
        settle();
        push("R5 kept div", int'(de[0]), 3);
        push("R6 err set", int'(er[0]), 1);
        repeat (10) @(negedge clk);
        push("R6 err sticky", int'(er[0]), 1);
        rd_pulse();
        @(negedge clk);
        push("R6 err cleared", int'(er[0]), 0);

        // R10 bit 0 set outside field, R9 autoidle follows inverted bit
        wr(0, 32'h8000_0031);
        settle();
        push("R10 div", int'(de[0]), 4);
        push("R9 autoidle", int'(ai[0]), 0);
        chk_clock("R8 even", 0, 4);

        // R8 divisor 1 passes input clock
        wr(0, 32'h8000_0000);
        settle();
        push("R1 div one", int'(de[0]), 1);
        chk_clock("R8 bypass", 0, 1);

        // R2 direct encoding
        wr(1, 32'd5);
        settle();
        push("R2 div", int'(de[1]), 5);
        chk_clock("R8 div5", 1, 5);
        wr(1, 32'd0);
        settle();
        push("R2 zero kept", int'(de[1]), 5);
        push("R2 zero err", int'(er[1]), 1);
        rd_pulse();
        wr(1, 32'd1);
        settle();
        push("R5 below min kept", int'(de[1]), 5);
        push("R5 below min err", int'(er[1]), 1);
        rd_pulse();

        // R3 power of two
        wr(2, 32'h0000_0200);
        settle();
        push("R3 div4", int'(de[2]), 4);
        wr(2, 32'h0000_03FF);
        settle();
        push("R3 R10 div8", int'(de[2]), 8);
        chk_clock("R3 clock", 2, 8);
        wr(2, 32'h0000_0600);
        settle();
        push("R5 pow kept", int'(de[2]), 8);
        push("R5 pow err", int'(er[2]), 1);
        rd_pulse();

        // R4 table
        wr(3, 32'd3);
        settle();
        push("R4 idx3", int'(de[3]), 16);
        wr(3, 32'd2);
        repeat (60) @(negedge clk);
        push("R4 hole kept", int'(de[3]), 16);
        push("R4 hole err", int'(er[3]), 1);
        rd_pulse();
        wr(3, 32'd6);
        repeat (60) @(negedge clk);
        push("R4 idx6 no limits", int'(de[3]), 6);
        wr(3, 32'd9);
        settle();
        push("R4 past end kept", int'(de[3]), 6);
        push("R4 past end err", int'(er[3]), 1);
        rd_pulse();
        wr(3, 32'd7);
        settle();
        push("R4 idx7", int'(de[3]), 3);
        chk_clock("R4 clock", 3, 3);

        done = 1;
        finish_run();
    end
endmodule